// File: doc/BRIEF.md
# Dual-Clock First-Word-Fall-Through FIFO with Rewind

This block is a FIFO whose write and read sides run on separate, unrelated clocks. The oldest stored word is always shown on the read data port, and `outReady` is high whenever that word is valid. A read enable consumes the shown word, and the next word then falls into its place. `inReady` is high whenever the FIFO can accept a write. The output register counts as one extra storage slot, so the FIFO holds DEPTH+1 words.

A rewind strobe on the read side restarts reading from the first word written after the last reset. This lets a consumer replay a short packet without the producer sending it again. The rewind latency is chosen by a mode pin that is sampled only while master reset is asserted. With the pin low, the first word is on the output right after the clock edge that samples the strobe, even if the FIFO had been drained. With the pin high, the output drops to not-ready for one read cycle before the first word reappears. A partial reset empties the FIFO and keeps the chosen mode.

A rewind is only legal in two cases. At least two words must have been written, and those words must be visible on the read side. Also, no more than DEPTH-1 words may be written between the reset and the rewind.

Top module: `fwft_rt_fifo`

## Requirements
- R1: After a master or a partial reset, `outReady` is low and `inReady` is high.
- R2: A written word reaches `rdData` with `outReady` high without any read enable. Each read enable given while `outReady` is high moves to the next word, in write order. When the FIFO is drained, `outReady` goes low.
- R3: With no reads, exactly DEPTH+1 writes are accepted before `inReady` stays low. A write attempted while `inReady` is low is dropped and never appears on the output.
- R4: A read enable given while `outReady` is low has no effect on the data later presented.
- R5: In zero-latency mode (`rtModeSel` low at master reset), the read-clock edge that samples `rtReq` leaves `outReady` high and `rdData` equal to the first word written after reset. Further reads then return the second word, the third word, and so on.
- R6: In zero-latency mode, a rewind applied when the FIFO is drained (`outReady` low) raises `outReady` on that same edge and presents the first word.
- R7: In normal mode (`rtModeSel` high at master reset), `outReady` is low for the one read cycle after the rewind edge. It is high with the first word after the next read-clock edge.
- R8: A partial reset does not change the rewind mode, whatever value `rtModeSel` has during that partial reset.
- R9: After a zero-latency rewind, the write side counts the rewound words as occupied again. Once the pointers have crossed, DEPTH minus the number of words still held in the RAM can be written before `inReady` falls.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wrClk | input | 1 | Write-side clock |
| rdClk | input | 1 | Read-side clock |
| mstRst | input | 1 | Master reset, synchronous in each domain, active high; samples the mode pin |
| prtRst | input | 1 | Partial reset, synchronous in each domain, active high; keeps the mode |
| rtModeSel | input | 1 | Rewind mode, sampled during master reset: 0 zero-latency, 1 normal |
| wrEn | input | 1 | Write request |
| wrData | input | DATA_W | Write data |
| inReady | output | 1 | FIFO can accept a write this write cycle |
| rdEn | input | 1 | Consume the presented word |
| rtReq | input | 1 | Rewind strobe, sampled on the read clock |
| rdData | output | DATA_W | Presented word |
| outReady | output | 1 | `rdData` holds a valid word |

## Verification
The hardest situation to reach from the ports is a zero-latency rewind on a FIFO that has been fully drained. The RAM is then empty from the read side's view, while the write pointer has already moved past the first word. The stimulus first writes a few words and waits until they have crossed into the read domain. It then reads every word out until `outReady` falls, and only then pulses the rewind. A related case is the free space seen after a rewind. To check it, the bench drains part of the FIFO, rewinds, waits for the pointer to cross back, and then fills until writes stall. The count of accepted writes shows that the rewound words are again counted as held.

// File: rtl/fwft_rt_pkg.sv
package fwft_rt_pkg;

  // Per-cycle strobes from control to datapath.
  typedef struct packed {
    logic memWrite;  // write-clock domain: store wrData at wrAddr
    logic outLoad;   // read-clock domain: load output register from rdAddr
  } dpStrobe_t;

endpackage

// File: rtl/fwft_gray_sync.sv
module fwft_gray_sync #(
  parameter int W      = 5,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);

  logic [W-1:0] stageQ [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stageQ[i] <= '0;
    end else begin
      stageQ[0] <= din;
      for (int i = 1; i < STAGES; i++) stageQ[i] <= stageQ[i-1];
    end
  end

  assign dout = stageQ[STAGES-1];

endmodule

// File: rtl/fwft_rt_ctrl.sv
module fwft_rt_ctrl
  import fwft_rt_pkg::*;
#(
  parameter int DEPTH       = 16,
  parameter int SYNC_STAGES = 2,
  localparam int AW         = $clog2(DEPTH)
) (
  input  logic          wrClk,
  input  logic          rdClk,
  input  logic          mstRst,
  input  logic          rstAny,
  input  logic          rtModeSel,
  input  logic          wrEn,
  input  logic          rdEn,
  input  logic          rtReq,
  output logic          inReady,
  output logic          outReady,
  output logic [AW-1:0] wrAddr,
  output logic [AW-1:0] rdAddr,
  output dpStrobe_t     strb
);

  localparam logic [AW:0] PTR_ONE  = (AW+1)'(1);
  localparam logic [AW:0] PTR_SPAN = (AW+1)'(DEPTH);

  function automatic logic [AW:0] toGray(input logic [AW:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [AW:0] fromGray(input logic [AW:0] g);
    logic [AW:0] b;
    b[AW] = g[AW];
    for (int i = AW - 1; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  // ---------------- write domain ----------------
  logic [AW:0] wrBin, wrGray, rdGraySync, rdBinSync, wrOcc;
  logic        wrFull, wrAccept;

  fwft_gray_sync #(.W(AW+1), .STAGES(SYNC_STAGES)) u_rd2wr (
    .clk (wrClk),
    .rst (rstAny),
    .din (rdGray),
    .dout(rdGraySync)
  );

  assign wrFull   = (wrGray == {~rdGraySync[AW:AW-1], rdGraySync[AW-2:0]});
  assign wrAccept = wrEn && !wrFull;
  assign inReady  = !wrFull;
  assign wrAddr   = wrBin[AW-1:0];

  always_ff @(posedge wrClk) begin
    if (rstAny) begin
      wrBin  <= '0;
      wrGray <= '0;
    end else if (wrAccept) begin
      wrBin  <= wrBin + PTR_ONE;
      wrGray <= toGray(wrBin + PTR_ONE);
    end
  end

  assign rdBinSync = fromGray(rdGraySync);
  assign wrOcc     = wrBin - rdBinSync;

  // R3: the write side never holds more than DEPTH words in the RAM
  p_no_overflow_r3: assert property (@(posedge wrClk) disable iff (rstAny)
    wrOcc <= PTR_SPAN);

  // ---------------- read domain ----------------
  logic [AW:0] rdBin, rdGray, wrGraySync, wrBinSync, rdOcc, rdBinNext;
  logic        outValid, validNext, loadOut, ramEmpty, zeroLat;

  fwft_gray_sync #(.W(AW+1), .STAGES(SYNC_STAGES)) u_wr2rd (
    .clk (rdClk),
    .rst (rstAny),
    .din (wrGray),
    .dout(wrGraySync)
  );

  assign ramEmpty = (rdGray == wrGraySync);

  always_comb begin
    rdBinNext = rdBin;
    validNext = outValid;
    loadOut   = 1'b0;
    rdAddr    = rdBin[AW-1:0];
    if (rtReq) begin
      if (zeroLat) begin
        loadOut   = 1'b1;
        rdAddr    = '0;
        rdBinNext = PTR_ONE;
        validNext = 1'b1;
      end else begin
        rdBinNext = '0;
        validNext = 1'b0;
      end
    end else if (!ramEmpty && (!outValid || rdEn)) begin
      loadOut   = 1'b1;
      rdBinNext = rdBin + PTR_ONE;
      validNext = 1'b1;
    end else if (rdEn) begin
      validNext = 1'b0;
    end
  end

  always_ff @(posedge rdClk) begin
    if (rstAny) begin
      rdBin    <= '0;
      rdGray   <= '0;
      outValid <= 1'b0;
    end else begin
      rdBin    <= rdBinNext;
      rdGray   <= toGray(rdBinNext);
      outValid <= validNext;
    end
  end

  // Mode is captured only by master reset (R8: partial reset leaves it).
  always_ff @(posedge rdClk) begin
    if (mstRst) zeroLat <= !rtModeSel;
  end

  assign outReady  = outValid;
  assign wrBinSync = fromGray(wrGraySync);
  assign rdOcc     = wrBinSync - rdBin;
  assign strb      = '{memWrite: wrAccept, outLoad: loadOut};

  // R2: reads never run past the words the read side has seen written
  p_rd_no_overrun_r2: assert property (@(posedge rdClk) disable iff (rstAny)
    rdOcc <= PTR_SPAN);

  // R5: zero-latency rewind presents valid data on the very next edge
  p_rt_zero_latency_r5: assert property (@(posedge rdClk) disable iff (rstAny)
    (rtReq && zeroLat) |=> (outValid && rdBin == PTR_ONE));

  // R7: normal rewind leaves a one-cycle gap with the pointer at start
  p_rt_normal_gap_r7: assert property (@(posedge rdClk) disable iff (rstAny)
    (rtReq && !zeroLat) |=> (!outValid && rdBin == '0));

endmodule

// File: rtl/fwft_rt_datapath.sv
module fwft_rt_datapath
  import fwft_rt_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              wrClk,
  input  logic              rdClk,
  input  logic              rstAny,
  input  dpStrobe_t         strb,
  input  logic [AW-1:0]     wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [AW-1:0]     rdAddr,
  output logic [DATA_W-1:0] rdData
);

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge wrClk) begin
    if (strb.memWrite) mem[wrAddr] <= wrData;
  end

  always_ff @(posedge rdClk) begin
    if (rstAny)            rdData <= '0;
    else if (strb.outLoad) rdData <= mem[rdAddr];
  end

  // R4: the presented word only changes when control loads a new one
  p_out_hold_r4: assert property (@(posedge rdClk) disable iff (rstAny)
    !strb.outLoad |=> $stable(rdData));

endmodule

// File: rtl/fwft_rt_fifo.sv
module fwft_rt_fifo
  import fwft_rt_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int DEPTH       = 16,
  parameter int SYNC_STAGES = 2,
  localparam int AW         = $clog2(DEPTH)
) (
  input  logic              wrClk,
  input  logic              rdClk,
  input  logic              mstRst,
  input  logic              prtRst,
  input  logic              rtModeSel,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  output logic              inReady,
  input  logic              rdEn,
  input  logic              rtReq,
  output logic [DATA_W-1:0] rdData,
  output logic              outReady
);

  logic          rstAny;
  logic [AW-1:0] wrAddr, rdAddr;
  dpStrobe_t     strb;

  assign rstAny = mstRst || prtRst;

  fwft_rt_ctrl #(.DEPTH(DEPTH), .SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .wrClk    (wrClk),
    .rdClk    (rdClk),
    .mstRst   (mstRst),
    .rstAny   (rstAny),
    .rtModeSel(rtModeSel),
    .wrEn     (wrEn),
    .rdEn     (rdEn),
    .rtReq    (rtReq),
    .inReady  (inReady),
    .outReady (outReady),
    .wrAddr   (wrAddr),
    .rdAddr   (rdAddr),
    .strb     (strb)
  );

  fwft_rt_datapath #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_dp (
    .wrClk (wrClk),
    .rdClk (rdClk),
    .rstAny(rstAny),
    .strb  (strb),
    .wrAddr(wrAddr),
    .wrData(wrData),
    .rdAddr(rdAddr),
    .rdData(rdData)
  );

endmodule

// File: tb/sim_fwft_rt_fifo.sv
module sim_fwft_rt_fifo;

  localparam int DATA_W = 8;
  localparam int DEPTH  = 16;

  logic              wrClk = 1'b0, rdClk = 1'b0;
  logic              mstRst = 1'b1, prtRst = 1'b0, rtModeSel = 1'b0;
  logic              wrEn = 1'b0, rdEn = 1'b0, rtReq = 1'b0;
  logic [DATA_W-1:0] wrData = '0;
  logic [DATA_W-1:0] rdData;
  logic              inReady, outReady;

  int  checkCnt = 0;
  int  failCnt  = 0;
  bit  done     = 1'b0;

  always #4 wrClk = ~wrClk;                     // 125 MHz
  initial begin #3; forever #4 rdClk = ~rdClk; end

  fwft_rt_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u0 (
    .wrClk(wrClk), .rdClk(rdClk), .mstRst(mstRst), .prtRst(prtRst),
    .rtModeSel(rtModeSel), .wrEn(wrEn), .wrData(wrData), .inReady(inReady),
    .rdEn(rdEn), .rtReq(rtReq), .rdData(rdData), .outReady(outReady)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checkCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic doReset(input bit master, input bit modeBit);
    @(negedge wrClk);
    wrEn = 1'b0; rdEn = 1'b0; rtReq = 1'b0;
    mstRst = master; prtRst = !master; rtModeSel = modeBit;
    repeat (4) @(negedge rdClk);
    mstRst = 1'b0; prtRst = 1'b0;
    repeat (2) @(negedge rdClk);
  endtask

  task automatic writeWords(input int n, input int base);
    int k;
    k = 0;
    while (k < n) begin
      @(negedge wrClk);
      if (inReady) begin wrEn = 1'b1; wrData = DATA_W'(base + k); k++; end
      else wrEn = 1'b0;
    end
    @(negedge wrClk); wrEn = 1'b0;
  endtask

  task automatic fillUntilStall(input int base, output int accepted);
    int idle;
    idle = 0; accepted = 0;
    while (idle < 12) begin
      @(negedge wrClk);
      if (inReady) begin
        wrEn = 1'b1; wrData = DATA_W'(base + accepted); accepted++; idle = 0;
      end else begin
        wrEn = 1'b0; idle++;
      end
    end
    @(negedge wrClk); wrEn = 1'b0;
  endtask

  task automatic readSeq(input string req, input int n, input int base);
    for (int k = 0; k < n; k++) begin
      int tries;
      tries = 0;
      @(negedge rdClk); rdEn = 1'b0;
      while (!outReady && tries < 20) begin @(negedge rdClk); tries++; end
      check(req, outReady, 1);
      check(req, rdData, DATA_W'(base + k));
      rdEn = 1'b1;
    end
    @(negedge rdClk); rdEn = 1'b0;
  endtask

  task automatic pulseRt();
    @(negedge rdClk); rdEn = 1'b0; rtReq = 1'b1;
    @(negedge rdClk); rtReq = 1'b0;
  endtask

  task automatic settle();
    repeat (8) @(negedge rdClk);
  endtask

  // R1 and R4
  task automatic t_reset_and_idle_read();
    doReset(1'b1, 1'b0);
    check("R1 outReady after master reset", outReady, 0);
    check("R1 inReady after master reset", inReady, 1);
    @(negedge rdClk); rdEn = 1'b1;             // reads on an empty FIFO
    repeat (3) @(negedge rdClk);
    rdEn = 1'b0;
    check("R4 outReady stays low", outReady, 0);
  endtask

  // R2 (and R4: earlier idle reads lost nothing)
  task automatic t_fwft_order();
    writeWords(5, 'h10);
    settle();
    check("R2 first word falls through", outReady, 1);
    check("R4 first word intact after idle reads", rdData, 'h10);
    readSeq("R2 in-order read", 5, 'h10);
    settle();
    check("R2 outReady low when drained", outReady, 0);
  endtask

  // R3
  task automatic t_capacity();
    int acc;
    doReset(1'b1, 1'b0);
    fillUntilStall('h40, acc);
    check("R3 accepted writes equal DEPTH+1", acc, DEPTH + 1);
    @(negedge wrClk);
    check("R3 inReady low when full", inReady, 0);
    wrEn = 1'b1; wrData = 'hEE;
    repeat (3) @(negedge wrClk);
    wrEn = 1'b0;
    readSeq("R3 full contents in order", DEPTH + 1, 'h40);
    settle();
    check("R3 dropped write not presented", outReady, 0);
  endtask

  // R5 and R6
  task automatic t_rt_zero_latency();
    doReset(1'b1, 1'b0);
    writeWords(4, 'h20);
    settle();
    readSeq("R2 partial read", 2, 'h20);
    pulseRt();
    check("R5 outReady on rewind edge", outReady, 1);
    check("R5 first word on rewind edge", rdData, 'h20);
    readSeq("R5 replay order", 4, 'h20);
    settle();
    check("R6 drained before rewind", outReady, 0);
    pulseRt();
    check("R6 outReady rises on empty rewind", outReady, 1);
    check("R6 first word on empty rewind", rdData, 'h20);
    readSeq("R6 replay order", 4, 'h20);
  endtask

  // R7
  task automatic t_rt_normal();
    doReset(1'b1, 1'b1);
    writeWords(3, 'h30);
    settle();
    readSeq("R2 partial read", 1, 'h30);
    pulseRt();
    check("R7 gap cycle after rewind", outReady, 0);
    @(negedge rdClk);
    check("R7 outReady after gap", outReady, 1);
    check("R7 first word after gap", rdData, 'h30);
    readSeq("R7 replay order", 3, 'h30);
  endtask

  // R8 and R1 after partial reset
  task automatic t_partial_keeps_mode();
    writeWords(2, 'h5E);
    settle();
    doReset(1'b0, 1'b0);                       // mode pin low during partial reset
    check("R1 outReady after partial reset", outReady, 0);
    check("R1 inReady after partial reset", inReady, 1);
    writeWords(3, 'h50);
    settle();
    check("R8 old contents cleared", rdData, 'h50);
    pulseRt();
    check("R8 normal-mode gap kept", outReady, 0);
    @(negedge rdClk);
    check("R8 first word after gap", rdData, 'h50);
    readSeq("R8 replay order", 3, 'h50);
  endtask

  // R9
  task automatic t_rt_frees_space();
    int acc;
    doReset(1'b1, 1'b0);
    writeWords(3, 'h60);
    settle();
    readSeq("R2 partial read", 2, 'h60);
    settle();
    pulseRt();
    repeat (10) @(negedge wrClk);
    fillUntilStall('h70, acc);
    check("R9 space after rewind", acc, DEPTH - 2);
    readSeq("R9 rewound words", 3, 'h60);
    readSeq("R9 new words", DEPTH - 2, 'h70);
  endtask

  initial begin
    repeat (100000) @(posedge wrClk);
    if (!done) begin
      checkCnt++; failCnt++;
      $display("FAIL watchdog actual=%0d expected=%0d", checkCnt, 0);
      $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
      $finish;
    end
  end

  initial begin
    t_reset_and_idle_read();
    t_fwft_order();
    t_capacity();
    t_rt_zero_latency();
    t_rt_normal();
    t_partial_keeps_mode();
    t_rt_frees_space();
    done = 1'b1;
    $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
    $finish;
  end

endmodule